// File: doc/BRIEF.md
# Power-Good Strap Latch Sequencer

This block brings a clock generator from power-on to normal operation. A single input pin first serves as an active-low power-good strobe. While the strobe is high the block waits and does nothing. When a low level is seen after synchronization, the block captures its configuration straps once. The straps are a 3-bit CPU frequency select, a test-mode select and an alternate-output select. It then counts out a settling interval in reference-clock cycles and enables the clock outputs.

Once the first low has been taken, the same pin takes on a new meaning: it becomes an active-high power-down request. In normal mode the capture is one-shot, so later strobe edges and strap changes have no effect on the latched configuration. In test mode a high level on the pin sends the sequencer back to waiting, and the next low captures the straps again. The latched select is also decoded into the CPU rate in MHz. The alternate-output strap chooses what the shared differential pair carries: the CPU debug clock or the fifth serial reference clock.

Top module: `pwrgood_strap_seq`

## Requirements
- R1: While reset is asserted and right after it, `out_en`, `out_hiz` and `pd_req` are 0 and `fsel_q`, `test_q` and `alt_q` are 0.
- R2: While the pin stays high after reset, the outputs stay disabled and strap changes do not reach the latched outputs.
- R3: When the pin goes low, the straps present on it are latched and appear on `fsel_q`, `test_q` and `alt_q` SYNC_STAGES+2 clock edges after the pin change, and not earlier.
- R4: `out_en` rises exactly SYNC_STAGES+2+SETTLE_CYC edges after the pin goes low, where SETTLE_CYC = REF_KHZ*SETTLE_US/1000. The settling delay must be set above 0.25 ms, and outputs must be stable within 1.8 ms.
- R5: `cpu_mhz` decodes `fsel_q` as 101=100, 001=133, 011=166, 010=200, 000=266, 100=333, 110=400. Code 111 gives 0 with `fsel_rsvd`=1, and every other code gives `fsel_rsvd`=0.
- R6: In normal mode (`test_q`=0), once the straps are latched, later strap changes and pin transitions leave the latched outputs unchanged.
- R7: In normal mode, after the straps are latched, a high pin raises `pd_req` SYNC_STAGES edges later and drops `out_en`. A low pin clears `pd_req` and restores `out_en` with no new capture.
- R8: With `test_q`=1 the sequence ends with `out_hiz`=1 and `out_en`=0, and `pd_req` stays 0.
- R9: With `test_q`=1, a high pin returns the block to waiting, and the next low captures the straps anew.
- R10: `alt_q`=1 means the shared pair carries the CPU debug clock. `alt_q`=0 means it carries the fifth serial reference clock. The value follows the latched strap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| pg_pin | input | 1 | Power-good strobe (active low), later power-down request (active high) |
| fsel_pin | input | 3 | CPU frequency select strap |
| test_pin | input | 1 | Test-mode (high impedance) strap |
| alt_pin | input | 1 | Alternate-output strap for the shared pair |
| fsel_q | output | 3 | Latched frequency select |
| test_q | output | 1 | Latched test-mode select |
| alt_q | output | 1 | Latched pair select, 1 = CPU debug clock |
| cpu_mhz | output | 9 | Decoded CPU rate in MHz, 0 when reserved |
| fsel_rsvd | output | 1 | Latched select is the reserved code |
| out_en | output | 1 | Clock outputs enabled |
| out_hiz | output | 1 | Outputs held at high impedance (test mode) |
| pd_req | output | 1 | Power-down request to the clock tree |

## Verification
The bench builds the block with REF_KHZ=1000 and SETTLE_US=20, which makes the settling interval 20 cycles, and keeps the default two-stage synchronizer. With a window that short, every frequency code, the test-mode re-capture and the power-down round trip each take a full boot within a few dozen cycles. The bench can then check the edge on which the straps appear and the edge on which `out_en` rises, exactly, on every boot.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

  typedef enum logic [1:0] {
    ST_WAIT   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_SETTLE = 2'd2,
    ST_RUN    = 2'd3
  } pgs_state_e;

  typedef struct packed {
    logic [2:0] fsel;
    logic       test;
    logic       alt;
  } strap_t;

  localparam int STRAP_W = $bits(strap_t);
  localparam int RATE_W  = 9;

  function automatic logic [RATE_W-1:0] rate_mhz(input logic [2:0] code);
    logic [RATE_W-1:0] r;
    case (code)
      3'b101:  r = RATE_W'(100);
      3'b001:  r = RATE_W'(133);
      3'b011:  r = RATE_W'(166);
      3'b010:  r = RATE_W'(200);
      3'b000:  r = RATE_W'(266);
      3'b100:  r = RATE_W'(333);
      3'b110:  r = RATE_W'(400);
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pgs_sync.sv
module pgs_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [W-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= RST_VAL;
        else        stg <= d;
      end
      assign q = stg;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= {STAGES{RST_VAL}};
        else        stg <= {stg[STAGES-2:0], d};
      end
      assign q = stg[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/pgs_strap_reg.sv
module pgs_strap_reg
  import pgs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  strap_t            d,
  output strap_t            q,
  output logic [RATE_W-1:0] rate,
  output logic              rsvd
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (cap) q <= d;
  end

  assign rate = rate_mhz(q.fsel);
  assign rsvd = (q.fsel == 3'b111);

  // R3
  capture_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (q == $past(d)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(q));

endmodule

// File: rtl/pgs_settle_timer.sv
module pgs_settle_timer #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam int CW   = (CYC < 2) ? 1 : $clog2(CYC + 1);
  localparam int LAST = (CYC < 1) ? 0 : CYC - 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == CW'(LAST));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !done) |=> (!run || (cnt == $past(cnt) + 1'b1)));

endmodule

// File: rtl/pwrgood_strap_seq.sv
module pwrgood_strap_seq
  import pgs_pkg::*;
#(
  parameter int REF_KHZ     = 14318,
  parameter int SETTLE_US   = 300,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              pg_pin,
  input  logic [2:0]        fsel_pin,
  input  logic              test_pin,
  input  logic              alt_pin,
  output logic [2:0]        fsel_q,
  output logic              test_q,
  output logic              alt_q,
  output logic [8:0]        cpu_mhz,
  output logic              fsel_rsvd,
  output logic              out_en,
  output logic              out_hiz,
  output logic              pd_req
);

  localparam int SETTLE_CYC = (REF_KHZ * SETTLE_US) / 1000;
  localparam int AGE_W      = $clog2(SETTLE_CYC + 2);

  logic       pg_s;
  strap_t     strap_raw, strap_s, strap_q;
  pgs_state_e state, state_nx;
  logic       settle_done;
  logic       after_cap;

  assign strap_raw = '{fsel: fsel_pin, test: test_pin, alt: alt_pin};

  pgs_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pg_sync (
    .clk(clk_ref), .rst_n(rst_n), .d(pg_pin), .q(pg_s)
  );

  pgs_sync #(.W(STRAP_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_strap_sync (
    .clk(clk_ref), .rst_n(rst_n), .d(strap_raw), .q(strap_s)
  );

  pgs_strap_reg u_straps (
    .clk(clk_ref), .rst_n(rst_n),
    .cap(state == ST_SAMPLE),
    .d(strap_s), .q(strap_q),
    .rate(cpu_mhz), .rsvd(fsel_rsvd)
  );

  pgs_settle_timer #(.CYC(SETTLE_CYC)) u_timer (
    .clk(clk_ref), .rst_n(rst_n),
    .run(state == ST_SETTLE), .done(settle_done)
  );

  always_comb begin
    state_nx = state;
    case (state)
      ST_WAIT:   if (!pg_s) state_nx = ST_SAMPLE;
      ST_SAMPLE: state_nx = ST_SETTLE;
      ST_SETTLE: begin
        if (strap_q.test && pg_s) state_nx = ST_WAIT;
        else if (settle_done)     state_nx = ST_RUN;
      end
      ST_RUN:    if (strap_q.test && pg_s) state_nx = ST_WAIT;
      default:   state_nx = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) state <= ST_WAIT;
    else        state <= state_nx;
  end

  assign after_cap = (state == ST_SETTLE) || (state == ST_RUN);
  assign fsel_q    = strap_q.fsel;
  assign test_q    = strap_q.test;
  assign alt_q     = strap_q.alt;
  assign pd_req    = after_cap && !strap_q.test && pg_s;
  assign out_en    = (state == ST_RUN) && !strap_q.test && !pg_s;
  assign out_hiz   = (state == ST_RUN) && strap_q.test;

  // Settling-age counter that runs beside the timer.
  logic [AGE_W-1:0] settle_age;
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)                   settle_age <= '0;
    else if (state == ST_SETTLE)  settle_age <= settle_age + 1'b1;
    else                          settle_age <= '0;
  end

  // R4
  settle_len_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (state == ST_RUN && $past(state) == ST_SETTLE) |-> (settle_age == AGE_W'(SETTLE_CYC)));

  // R4
  settle_bound_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (state == ST_SETTLE) |-> (settle_age < AGE_W'(SETTLE_CYC)));

  // R7
  pd_blocks_en_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    pd_req |-> !out_en);

  // R8
  hiz_excl_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    out_hiz |-> (!out_en && !pd_req));

  // R6
  one_shot_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!test_q && after_cap && $past(after_cap)) |-> $stable(fsel_q));

endmodule

// File: tb/pwrgood_strap_seq_test.sv
module pwrgood_strap_seq_test;

  localparam int REF_KHZ   = 1000;
  localparam int SETTLE_US = 20;
  localparam int N         = (REF_KHZ * SETTLE_US) / 1000;

  logic       clk_ref = 1'b0;
  logic       rst_n   = 1'b0;
  logic       pg_pin  = 1'b1;
  logic [2:0] fsel_pin = '0;
  logic       test_pin = 1'b0;
  logic       alt_pin  = 1'b0;
  logic [2:0] fsel_q;
  logic       test_q, alt_q;
  logic [8:0] cpu_mhz;
  logic       fsel_rsvd, out_en, out_hiz, pd_req;

  int nvec  = 0;
  int nfail = 0;

  always #2 clk_ref = ~clk_ref;

  pwrgood_strap_seq #(.REF_KHZ(REF_KHZ), .SETTLE_US(SETTLE_US), .SYNC_STAGES(2)) uut (
    .clk_ref, .rst_n, .pg_pin, .fsel_pin, .test_pin, .alt_pin,
    .fsel_q, .test_q, .alt_q, .cpu_mhz, .fsel_rsvd, .out_en, .out_hiz, .pd_req
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk_ref);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_rate(input logic [2:0] c);
    case (c)
      3'b000: return 266;
      3'b001: return 133;
      3'b010: return 200;
      3'b011: return 166;
      3'b100: return 333;
      3'b101: return 100;
      3'b110: return 400;
      default: return 0;
    endcase
  endfunction

  // Reset with the given straps, then drop the pin just after an edge.
  task automatic boot(input logic [2:0] f, input logic t, input logic a);
    fsel_pin = f; test_pin = t; alt_pin = a; pg_pin = 1'b1;
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(3);
    pg_pin = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; pg_pin = 1'b1; fsel_pin = 3'b111; test_pin = 1'b1; alt_pin = 1'b1;
    tick(3);
    chk("R1 out_en", out_en, 0);
    chk("R1 out_hiz", out_hiz, 0);
    chk("R1 pd_req", pd_req, 0);
    chk("R1 latched straps", {fsel_q, test_q, alt_q}, 0);
  endtask

  task automatic t_idle;
    rst_n = 1'b1;
    tick(30);
    fsel_pin = 3'b010; test_pin = 1'b0; alt_pin = 1'b0;
    tick(20);
    chk("R2 out_en while waiting", out_en, 0);
    chk("R2 pd_req while waiting", pd_req, 0);
    chk("R2 straps not latched", {fsel_q, test_q, alt_q}, 5'b11111 & 5'b0);
  endtask

  task automatic t_boot;
    boot(3'b011, 1'b0, 1'b1);
    tick(3);
    chk("R3 straps not yet latched", fsel_q, 0);
    tick(1);
    chk("R3 fsel latched", fsel_q, 3);
    chk("R10 alt latched as debug clock", alt_q, 1);
    chk("R5 rate 166", cpu_mhz, 166);
    tick(N - 1);
    chk("R4 out_en one edge early", out_en, 0);
    tick(1);
    chk("R4 out_en on time", out_en, 1);
  endtask

  task automatic t_ignore;
    fsel_pin = 3'b110; alt_pin = 1'b0; test_pin = 1'b1;
    tick(10);
    chk("R6 fsel held", fsel_q, 3);
    chk("R6 alt held", alt_q, 1);
    chk("R6 test held", test_q, 0);
    chk("R6 outputs stay enabled", out_en, 1);
  endtask

  task automatic t_pd;
    pg_pin = 1'b1;
    tick(1);
    chk("R7 pd_req before sync", pd_req, 0);
    tick(1);
    chk("R7 pd_req raised", pd_req, 1);
    chk("R7 out_en dropped", out_en, 0);
    fsel_pin = 3'b000;
    tick(5);
    pg_pin = 1'b0;
    tick(2);
    chk("R7 pd_req cleared", pd_req, 0);
    chk("R7 out_en restored", out_en, 1);
    chk("R6 no recapture after power-down", fsel_q, 3);
  endtask

  task automatic t_rates;
    for (int c = 0; c < 8; c++) begin
      boot(3'(c), 1'b0, 1'b0);
      tick(4 + N);
      chk("R5 rate decode", cpu_mhz, exp_rate(3'(c)));
      chk("R5 reserved flag", fsel_rsvd, (c == 7) ? 1 : 0);
      chk("R10 alt selects serial ref", alt_q, 0);
    end
  endtask

  task automatic t_test_mode;
    boot(3'b010, 1'b1, 1'b0);
    tick(4 + N);
    chk("R8 hiz in test mode", out_hiz, 1);
    chk("R8 out_en off in test mode", out_en, 0);
    pg_pin = 1'b1;
    tick(2);
    chk("R8 no pd_req in test mode", pd_req, 0);
    tick(1);
    chk("R9 back to waiting", out_hiz, 0);
    fsel_pin = 3'b110; test_pin = 1'b1; alt_pin = 1'b1;
    tick(5);
    pg_pin = 1'b0;
    tick(3);
    chk("R9 not yet recaptured", fsel_q, 2);
    tick(1);
    chk("R9 recaptured fsel", fsel_q, 6);
    chk("R9 recaptured alt", alt_q, 1);
    tick(N);
    chk("R9 hiz after recapture", out_hiz, 1);
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_boot();
    t_ignore();
    t_pd();
    t_rates();
    t_test_mode();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule